// File: doc/BRIEF.md
# Crosspoint Routing Configuration Controller

This block holds the routing state of a 68-output by 68-input crosspoint. Every output owns a 7-bit select register naming the one input it carries, or a disable code that switches the output off. A second, 69th select register names the input that feeds an activity monitor. The block produces only these select values and the per-output enables. The switching fabric that uses them lies outside it.

Commands arrive on a synchronous parallel port with a valid/ready handshake. Each command carries an opcode, an output address and an input address. A write can go straight into an output's live select, or it can be parked in a pending bank. A commit command then moves every parked entry into the live bank on one clock edge. A burst command routes one input to every output over four consecutive cycles. While a burst runs, the port reports not ready. An active-low init input, sampled on the clock, restores the straight-through map. It also clears the pending bank and points the monitor at input 0.

Top module: `xpt_cfg_ctrl`

## Requirements
- R1: The select for output o appears on outSel[o*7 +: 7]. Values 0..67 name an input and 127 is the disable code. outEnable[o] is 0 exactly when that select holds 127. No other select value is ever present.
- R2: After reset, and at the edge after any rising clock edge where initN is low, outSel for output o equals o and every outEnable bit is 1. At the same point monSel is 0 and no pending entry remains. A command presented in an init cycle has no effect.
- R3: A write-immediate command (opcode 0) is accepted at a rising edge where cmdValid and cmdReady are both high. From that edge, output cmdOut shows cmdIn. All other outputs keep their values.
- R4: A write-queued command (opcode 1) stores cmdIn as the pending entry for cmdOut and leaves all outputs unchanged. A later queued write to the same output replaces the entry.
- R5: A commit command (opcode 2) copies every pending entry into its output on one clock edge and then clears all pending entries. A second commit with no new queued writes therefore changes nothing.
- R6: A burst command (opcode 3) with a legal cmdIn routes cmdIn to all outputs. In the k-th cycle after acceptance (k = 1..4) it writes outputs 17(k-1) through 17(k-1)+16. cmdReady is low for exactly those 4 cycles.
- R7: Writing the disable code 127, by an immediate, queued or burst command, turns the output off.
- R8: A write or burst whose cmdIn is in 68..126, or a write whose cmdOut is 68 or above, is rejected and leaves every select unchanged. Opcodes 5..7 have no effect.
- R9: A set-monitor command (opcode 4) loads monSel with cmdIn when cmdIn is below 68. Any other value, including 127, is ignored.
- R10: cmdReady is high whenever no burst is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| initN | input | 1 | Synchronous active-low straight-through init |
| cmdValid | input | 1 | Command present |
| cmdReady | output | 1 | Command can be accepted |
| cmdOp | input | 3 | Opcode: 0 write-immediate, 1 write-queued, 2 commit, 3 burst, 4 set-monitor |
| cmdOut | input | 7 | Output address |
| cmdIn | input | 7 | Input address or disable code |
| outSel | output | 476 | Live select of each output, 7 bits per output |
| outEnable | output | 68 | Per-output enable, low when disabled |
| monSel | output | 7 | Monitor selector input |

## Verification
Several properties are checked on every cycle. Every live select and the monitor select stay legal, and an init cycle always leaves the straight-through map with all outputs enabled. An accepted burst drops ready, and ready never stays low for more than four cycles. Queued writes and rejected writes leave the outputs untouched. Other behaviour needs the bench's scenarios: the group order within a burst, the all-at-once effect of commit, the clearing of pending entries, the replacement of a pending entry, and init overriding a command in the same cycle. The bench shows these against a model it keeps of the live bank, the pending bank and the monitor.

// File: rtl/xpt_pkg.sv
package xpt_pkg;
  localparam int SEL_W = 7;

  typedef enum logic [2:0] {
    OP_WR_NOW   = 3'd0,
    OP_WR_STAGE = 3'd1,
    OP_COMMIT   = 3'd2,
    OP_BURST    = 3'd3,
    OP_SET_MON  = 3'd4
  } op_e;

  typedef struct packed {
    logic             initLoad;
    logic             wrActive;
    logic             wrPending;
    logic             commit;
    logic             setMon;
    logic             burstWr;
    logic [SEL_W-1:0] burstGrp;
    logic [SEL_W-1:0] addrOut;
    logic [SEL_W-1:0] addrIn;
  } strobe_t;
endpackage

// File: rtl/xpt_ctrl.sv
module xpt_ctrl
  import xpt_pkg::*;
#(
  parameter int NUM_OUT      = 68,
  parameter int NUM_IN       = 68,
  parameter int BURST_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             initN,
  input  logic             cmdValid,
  output logic             cmdReady,
  input  logic [2:0]       cmdOp,
  input  logic [SEL_W-1:0] cmdOut,
  input  logic [SEL_W-1:0] cmdIn,
  output strobe_t          stb
);
  localparam int GRP_W = (BURST_CYCLES > 1) ? $clog2(BURST_CYCLES) : 1;
  localparam logic [GRP_W-1:0] LAST_GRP = GRP_W'(BURST_CYCLES - 1);
  localparam logic [SEL_W-1:0] DIS_CODE = {SEL_W{1'b1}};

  logic             busy;
  logic [GRP_W-1:0] grp;
  logic [SEL_W-1:0] burstIn;
  logic             accept;
  logic             inOk;
  logic             outOk;
  logic             monOk;

  assign cmdReady = !busy;
  assign accept   = cmdValid && cmdReady && initN;
  assign monOk    = int'(cmdIn) < NUM_IN;
  assign inOk     = monOk || (cmdIn == DIS_CODE);
  assign outOk    = int'(cmdOut) < NUM_OUT;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      grp     <= '0;
      burstIn <= '0;
    end else if (!initN) begin
      busy <= 1'b0;
      grp  <= '0;
    end else if (busy) begin
      if (grp == LAST_GRP) begin
        busy <= 1'b0;
        grp  <= '0;
      end else begin
        grp <= grp + 1'b1;
      end
    end else if (accept && (op_e'(cmdOp) == OP_BURST) && inOk) begin
      busy    <= 1'b1;
      grp     <= '0;
      burstIn <= cmdIn;
    end
  end

  always_comb begin
    stb          = '0;
    stb.initLoad = !initN;
    stb.addrOut  = cmdOut;
    stb.addrIn   = busy ? burstIn : cmdIn;
    stb.burstWr  = busy && initN;
    stb.burstGrp = SEL_W'(grp);
    if (accept) begin
      case (op_e'(cmdOp))
        OP_WR_NOW:   stb.wrActive  = inOk && outOk;
        OP_WR_STAGE: stb.wrPending = inOk && outOk;
        OP_COMMIT:   stb.commit    = 1'b1;
        OP_SET_MON:  stb.setMon    = monOk;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/xpt_datapath.sv
module xpt_datapath
  import xpt_pkg::*;
#(
  parameter int NUM_OUT      = 68,
  parameter int BURST_CYCLES = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  stb,
  output logic [NUM_OUT*SEL_W-1:0] outSel,
  output logic [NUM_OUT-1:0]       outEnable,
  output logic [SEL_W-1:0]         monSel
);
  localparam int PER_GRP = (NUM_OUT + BURST_CYCLES - 1) / BURST_CYCLES;
  localparam logic [SEL_W-1:0] DIS_CODE = {SEL_W{1'b1}};

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
    localparam logic [SEL_W-1:0] MY_ADDR = SEL_W'(o);
    localparam logic [SEL_W-1:0] MY_GRP  = SEL_W'(o / PER_GRP);
    logic [SEL_W-1:0] activeSel;
    logic [SEL_W-1:0] pendSel;
    logic             pendVld;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        activeSel <= MY_ADDR;
        pendSel   <= '0;
        pendVld   <= 1'b0;
      end else if (stb.initLoad) begin
        activeSel <= MY_ADDR;
        pendVld   <= 1'b0;
      end else begin
        if (stb.burstWr && (stb.burstGrp == MY_GRP)) activeSel <= stb.addrIn;
        if (stb.commit && pendVld) begin
          activeSel <= pendSel;
          pendVld   <= 1'b0;
        end
        if (stb.wrActive && (stb.addrOut == MY_ADDR)) activeSel <= stb.addrIn;
        if (stb.wrPending && (stb.addrOut == MY_ADDR)) begin
          pendSel <= stb.addrIn;
          pendVld <= 1'b1;
        end
      end
    end

    assign outSel[o*SEL_W +: SEL_W] = activeSel;
    assign outEnable[o]             = (activeSel != DIS_CODE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             monSel <= '0;
    else if (stb.initLoad) monSel <= '0;
    else if (stb.setMon)   monSel <= stb.addrIn;
  end
endmodule

// File: rtl/xpt_cfg_ctrl.sv
module xpt_cfg_ctrl
  import xpt_pkg::*;
#(
  parameter int NUM_OUT      = 68,
  parameter int NUM_IN       = 68,
  parameter int BURST_CYCLES = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     initN,
  input  logic                     cmdValid,
  output logic                     cmdReady,
  input  logic [2:0]               cmdOp,
  input  logic [SEL_W-1:0]         cmdOut,
  input  logic [SEL_W-1:0]         cmdIn,
  output logic [NUM_OUT*SEL_W-1:0] outSel,
  output logic [NUM_OUT-1:0]       outEnable,
  output logic [SEL_W-1:0]         monSel
);
  strobe_t stb;

  xpt_ctrl #(
    .NUM_OUT(NUM_OUT), .NUM_IN(NUM_IN), .BURST_CYCLES(BURST_CYCLES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .initN(initN), .cmdValid(cmdValid),
    .cmdReady(cmdReady), .cmdOp(cmdOp), .cmdOut(cmdOut), .cmdIn(cmdIn),
    .stb(stb)
  );

  xpt_datapath #(
    .NUM_OUT(NUM_OUT), .BURST_CYCLES(BURST_CYCLES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .outSel(outSel),
    .outEnable(outEnable), .monSel(monSel)
  );
endmodule

// File: rtl/xpt_cfg_checker.sv
module xpt_cfg_checker
  import xpt_pkg::*;
#(
  parameter int NUM_OUT      = 68,
  parameter int NUM_IN       = 68,
  parameter int BURST_CYCLES = 4
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     initN,
  input logic                     cmdValid,
  input logic                     cmdReady,
  input logic [2:0]               cmdOp,
  input logic [SEL_W-1:0]         cmdOut,
  input logic [SEL_W-1:0]         cmdIn,
  input logic [NUM_OUT*SEL_W-1:0] outSel,
  input logic [NUM_OUT-1:0]       outEnable,
  input logic [SEL_W-1:0]         monSel
);
  localparam logic [SEL_W-1:0] DIS_CODE = {SEL_W{1'b1}};
  localparam int CNT_W = $clog2(BURST_CYCLES + 2);

  logic             acc;
  logic             legalIn;
  logic [CNT_W-1:0] lowCnt;

  assign acc     = cmdValid && cmdReady && initN;
  assign legalIn = (int'(cmdIn) < NUM_IN) || (cmdIn == DIS_CODE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                lowCnt <= '0;
    else if (cmdReady)        lowCnt <= '0;
    else if (lowCnt != '1)    lowCnt <= lowCnt + 1'b1;
  end

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_chk
    AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
      (int'(outSel[o*SEL_W +: SEL_W]) < NUM_IN) || (outSel[o*SEL_W +: SEL_W] == DIS_CODE)); // R1
    AST_INIT_MAP: assert property (@(posedge clk) disable iff (!rstN)
      !initN |=> outSel[o*SEL_W +: SEL_W] == SEL_W'(o)); // R2
  end

  AST_INIT_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    !initN |=> (&outEnable) && (monSel == '0)); // R2

  AST_QUEUE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (acc && cmdOp == 3'd1) |=> $stable(outSel)); // R4

  AST_BURST_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (acc && cmdOp == 3'd3 && legalIn) |=> !cmdReady); // R6

  AST_BURST_LEN: assert property (@(posedge clk) disable iff (!rstN)
    int'(lowCnt) <= BURST_CYCLES); // R6

  AST_REJECT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (acc && cmdOp == 3'd0 && (!legalIn || int'(cmdOut) >= NUM_OUT)) |=> $stable(outSel)); // R8

  AST_MON_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    int'(monSel) < NUM_IN); // R9
endmodule

bind xpt_cfg_ctrl xpt_cfg_checker #(
  .NUM_OUT(NUM_OUT), .NUM_IN(NUM_IN), .BURST_CYCLES(BURST_CYCLES)
) u_chk (
  .clk(clk), .rstN(rstN), .initN(initN), .cmdValid(cmdValid),
  .cmdReady(cmdReady), .cmdOp(cmdOp), .cmdOut(cmdOut), .cmdIn(cmdIn),
  .outSel(outSel), .outEnable(outEnable), .monSel(monSel)
);

// File: tb/test_xpt_cfg_ctrl.sv
`timescale 1ns/1ps
module test_xpt_cfg_ctrl;
  localparam int NO = 68;
  localparam int NI = 68;
  localparam int W  = 7;
  localparam int DIS = 127;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic initN = 1'b1;
  logic cmdValid = 1'b0;
  logic cmdReady;
  logic [2:0] cmdOp = '0;
  logic [W-1:0] cmdOut = '0;
  logic [W-1:0] cmdIn = '0;
  logic [NO*W-1:0] outSel;
  logic [NO-1:0] outEnable;
  logic [W-1:0] monSel;

  int checks = 0;
  int errors = 0;
  int expSel [NO];
  int expPend [NO];
  bit expPv [NO];
  int expMon;

  always #5 clk = ~clk;

  xpt_cfg_ctrl i_xpt_cfg_ctrl (
    .clk(clk), .rstN(rstN), .initN(initN), .cmdValid(cmdValid),
    .cmdReady(cmdReady), .cmdOp(cmdOp), .cmdOut(cmdOut), .cmdIn(cmdIn),
    .outSel(outSel), .outEnable(outEnable), .monSel(monSel)
  );

  task automatic checkVal(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic checkAll(string tag);
    int bad = 0;
    checks++;
    for (int o = 0; o < NO; o++) begin
      int g = int'(outSel[o*W +: W]);
      int ge = int'(outEnable[o]);
      int ee = (expSel[o] != DIS) ? 1 : 0;
      if (bad == 0 && (g != expSel[o] || ge != ee)) begin
        bad = 1;
        $display("FAIL %s out %0d got sel %0d en %0d expected sel %0d en %0d",
                 tag, o, g, ge, expSel[o], ee);
      end
    end
    if (bad == 0 && int'(monSel) != expMon) begin
      bad = 1;
      $display("FAIL %s monitor got %0d expected %0d", tag, monSel, expMon);
    end
    errors += bad;
  endtask

  function automatic bit inLegal(int v);
    return (v < NI) || (v == DIS);
  endfunction

  task automatic modelInit();
    for (int o = 0; o < NO; o++) begin
      expSel[o] = o;
      expPv[o] = 1'b0;
    end
    expMon = 0;
  endtask

  task automatic sendCmd(int op, int oa, int ia);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 3'(op); cmdOut = 7'(oa); cmdIn = 7'(ia);
    while (!cmdReady) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
    case (op)
      0: if (inLegal(ia) && oa < NO) expSel[oa] = ia;
      1: if (inLegal(ia) && oa < NO) begin expPend[oa] = ia; expPv[oa] = 1'b1; end
      2: for (int o = 0; o < NO; o++) if (expPv[o]) begin expSel[o] = expPend[o]; expPv[o] = 1'b0; end
      4: if (ia < NI) expMon = ia;
      default: ;
    endcase
  endtask

  task automatic doBurst(int ia);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 3'd3; cmdOut = '0; cmdIn = 7'(ia);
    @(posedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
    for (int k = 1; k <= 4; k++) begin
      checkVal("R6 ready low during burst", int'(cmdReady), 0);
      @(posedge clk);
      @(negedge clk);
      for (int o = 17*(k-1); o < 17*k; o++) expSel[o] = ia;
      checkAll($sformatf("R6 burst group %0d", k));
    end
    checkVal("R6 R10 ready back after 4 cycles", int'(cmdReady), 1);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    modelInit();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R2 reset straight-through");
    checkVal("R10 ready after reset", int'(cmdReady), 1);

    // R3: immediate write sweep, each output checked right after its edge
    for (int o = 0; o < NO; o++) begin
      sendCmd(0, o, (o * 5 + 3) % NI);
      checkAll("R3 write-immediate");
    end

    // R7 / R1: disable code through immediate writes
    sendCmd(0, 0, DIS);
    sendCmd(0, 67, DIS);
    sendCmd(0, 33, DIS);
    checkAll("R7 R1 disable immediate");

    // R8: illegal input values and out-of-range outputs
    for (int v = NI; v < DIS; v++) begin
      sendCmd(0, 10, v);
      sendCmd(1, 11, v);
    end
    checkAll("R8 illegal input rejected");
    for (int a = NO; a < 128; a += 7) sendCmd(0, a, 5);
    checkAll("R8 out-of-range output rejected");
    for (int op = 5; op < 8; op++) sendCmd(op, 2, 9);
    checkAll("R8 unused opcodes ignored");
    sendCmd(2, 0, 0);
    checkAll("R8 rejected queued writes left no pending");

    // R4 / R5: queued writes then commit
    for (int o = 0; o < NO; o += 2) begin
      sendCmd(1, o, (o * 3 + 1) % NI);
      checkAll("R4 queued write no output effect");
    end
    sendCmd(1, 4, DIS);
    sendCmd(1, 6, 50);
    sendCmd(1, 6, 51);
    checkAll("R4 pending replaced, outputs unchanged");
    sendCmd(2, 0, 0);
    checkAll("R5 commit applies all pending");
    checkVal("R7 queued disable", int'(outEnable[4]), 0);
    sendCmd(0, 0, 9);
    sendCmd(2, 0, 0);
    checkAll("R5 second commit no effect");

    // R6: bursts
    doBurst(42);
    doBurst(DIS);
    checkVal("R7 burst disable all", int'(|outEnable), 0);
    doBurst(0);
    sendCmd(3, 0, 100);
    checkVal("R8 illegal burst ready stays", int'(cmdReady), 1);
    checkAll("R8 illegal burst no change");

    // R9: monitor sweep and rejects
    for (int v = 0; v < NI; v++) begin
      sendCmd(4, 0, (v * 7 + 2) % NI);
      checkAll("R9 set monitor");
    end
    sendCmd(4, 0, 68);
    sendCmd(4, 0, DIS);
    checkAll("R9 illegal monitor ignored");

    // R2: init with command in the same cycle, pending cleared
    sendCmd(1, 20, 5);
    @(negedge clk);
    initN = 1'b0; cmdValid = 1'b1; cmdOp = 3'd0; cmdOut = 7'd3; cmdIn = 7'd30;
    @(posedge clk);
    @(negedge clk);
    initN = 1'b1; cmdValid = 1'b0;
    modelInit();
    checkAll("R2 init overrides command");
    sendCmd(2, 0, 0);
    checkAll("R2 init cleared pending");

    // R2: init aborts a burst
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 3'd3; cmdIn = 7'd12;
    @(posedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    initN = 1'b0;
    @(posedge clk);
    @(negedge clk);
    initN = 1'b1;
    checkAll("R2 init during burst");
    checkVal("R10 ready after aborted burst", int'(cmdReady), 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule